// File: doc/BRIEF.md
# FIFO Status and Error Register Block

This block holds a transmit FIFO and a receive FIFO, each 32 words of 32 bits, that sit between a bus-side register port and a serial engine. The bus pushes words into the transmit FIFO and the engine takes them out. The engine delivers received words into the receive FIFO and the bus pops them. The block reports the fill state of both queues through two read words. The status word carries live full and empty flags, sticky error flags, a ready flag and a live busy flag. The level word carries the number of free transmit slots and the number of filled receive entries.

Software clears the sticky flags by writing a 1 to their bit positions in the status word. Writing 1 to either flush position empties the matching FIFO in one cycle. A flush bit is a command, not state, so it always reads back as 0.

Top module: `fifo_stat_regs`

## Requirements
- R1: After reset the status word is 0x00A00000 (both empty flags set, everything else clear, with busy low), and the level word is 0x00000020 (32 free transmit slots at bits 5:0, 0 receive entries at bits 21:16).
- R2: Live flag positions in the status word are: transmit full at bit 20, transmit empty at bit 21, receive full at bit 22, receive empty at bit 23. Bits not named in these requirements read 0.
- R3: Words pushed by the bus leave the transmit FIFO on `eng_tx_word` in push order. The free-slot field drops by one per accepted push and rises by one per take. `eng_tx_word` reads 0 while the FIFO is empty.
- R4: Words delivered by the engine leave the receive FIFO on `host_rdata` in arrival order, and the filled-entry field tracks them.
- R5: A bus push while the transmit FIFO is full is dropped and sets the transmit-overflow flag at bit 19. The stored contents stay intact.
- R6: A bus pop while the receive FIFO is empty returns 0 and sets the receive-underflow flag at bit 18.
- R7: An engine take while the transmit FIFO is empty returns 0 and sets the transmit-underflow flag at bit 24. A push in the same cycle is still accepted.
- R8: An engine delivery while the receive FIFO is full is dropped, leaves the count at 32, and sets the receive-overflow flag at bit 25.
- R9: The error flags and the ready flag are sticky. A register write with a 1 at a flag's position clears it, and a 0 leaves it unchanged.
- R10: When a flag's set event and its clear write fall in the same cycle, the flag ends up set.
- R11: A write with bit 26 set empties the transmit FIFO, and one with bit 27 set empties the receive FIFO, each in one cycle. Counts return to their reset values, a push into that FIFO in the same cycle is discarded, and the flush bits read back 0.
- R12: The ready flag at bit 30 is set by an `eng_done` pulse. Bit 31 follows `eng_busy` in the same cycle.
- R13: The transmit full flag rises when the 32nd word is stored, when the free-slot field reads 0. Full and empty are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_push | input | 1 | Bus pushes `host_wdata` into the transmit FIFO |
| host_wdata | input | 32 | Word to push |
| host_pop | input | 1 | Bus pops the receive FIFO |
| host_rdata | output | 32 | Head of the receive FIFO, 0 when empty |
| eng_take | input | 1 | Engine consumes the transmit head |
| eng_tx_word | output | 32 | Head of the transmit FIFO, 0 when empty |
| eng_give | input | 1 | Engine delivers `eng_rx_word` into the receive FIFO |
| eng_rx_word | input | 32 | Word delivered by the engine |
| eng_busy | input | 1 | Live busy state of the engine |
| eng_done | input | 1 | Pulse that sets the ready flag |
| csr_wr | input | 1 | Write strobe for the status word (clear and flush) |
| csr_wdata | input | 32 | Write data for the status word |
| stat_word | output | 32 | Status word |
| level_word | output | 32 | Level word |

## Verification
The checker watches several properties on every cycle. It checks that a push into a full transmit FIFO latches overflow and that a take from an empty one latches underflow, even when a clear is written in the same cycle. It checks that a sticky flag holds without a clear, that a pop from an empty receive FIFO yields 0, and that a dropped delivery leaves the receive count unchanged. It also checks that a transmit flush restores 32 free slots and that full and empty never coincide. Only the bench's scenarios show the following: that words come out in the order they went in, that a dropped push leaves the stored words intact, and the exact values of both read words after each mixed sequence of pushes, pops, clears and flushes.

// File: rtl/fifo_stat_regs.sv
module fifo_stat_regs #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_push,
  input  logic [WIDTH-1:0] host_wdata,
  input  logic             host_pop,
  output logic [WIDTH-1:0] host_rdata,
  input  logic             eng_take,
  output logic [WIDTH-1:0] eng_tx_word,
  input  logic             eng_give,
  input  logic [WIDTH-1:0] eng_rx_word,
  input  logic             eng_busy,
  input  logic             eng_done,
  input  logic             csr_wr,
  input  logic [31:0]      csr_wdata,
  output logic [31:0]      stat_word,
  output logic [31:0]      level_word
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  // index 0 = transmit queue, index 1 = receive queue
  logic [1:0]       wr_req, rd_req, flush, full, empty, wr_ok, rd_ok;
  logic [WIDTH-1:0] wr_dat [2];
  logic [WIDTH-1:0] rd_dat [2];
  logic [CW-1:0]    cnt [2];

  assign wr_req    = {eng_give, host_push};
  assign rd_req    = {host_pop, eng_take};
  assign wr_dat[0] = host_wdata;
  assign wr_dat[1] = eng_rx_word;
  assign flush     = {2{csr_wr}} & csr_wdata[27:26];

  for (genvar gi = 0; gi < 2; gi++) begin : g_q
    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wp, rp;

    assign full[gi]   = (cnt[gi] == CW'(DEPTH));
    assign empty[gi]  = (cnt[gi] == '0);
    assign wr_ok[gi]  = wr_req[gi] & ~full[gi] & ~flush[gi];
    assign rd_ok[gi]  = rd_req[gi] & ~empty[gi] & ~flush[gi];
    assign rd_dat[gi] = empty[gi] ? '0 : store[rp];

    always_ff @(posedge clk)
      if (wr_ok[gi]) store[wp] <= wr_dat[gi];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wp      <= '0;
        rp      <= '0;
        cnt[gi] <= '0;
      end else if (flush[gi]) begin
        wp      <= '0;
        rp      <= '0;
        cnt[gi] <= '0;
      end else begin
        if (wr_ok[gi]) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
        if (rd_ok[gi]) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
        cnt[gi] <= cnt[gi] + CW'(wr_ok[gi]) - CW'(rd_ok[gi]);
      end
  end

  assign eng_tx_word = rd_dat[0];
  assign host_rdata  = rd_dat[1];

  // sticky flags: {ready, rx_ovf, tx_unf, tx_ovf, rx_unf}
  logic [4:0] flg, flg_set, flg_clr;
  assign flg_set = {eng_done, eng_give & full[1], eng_take & empty[0],
                    host_push & full[0], host_pop & empty[1]};
  assign flg_clr = {5{csr_wr}} & {csr_wdata[30], csr_wdata[25], csr_wdata[24],
                                  csr_wdata[19], csr_wdata[18]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flg <= '0;
    else        flg <= flg_set | (flg & ~flg_clr);

  always_comb begin
    stat_word     = '0;
    stat_word[31] = eng_busy;
    stat_word[30] = flg[4];
    stat_word[25] = flg[3];
    stat_word[24] = flg[2];
    stat_word[23] = empty[1];
    stat_word[22] = full[1];
    stat_word[21] = empty[0];
    stat_word[20] = full[0];
    stat_word[19] = flg[1];
    stat_word[18] = flg[0];
  end

  always_comb begin
    level_word        = '0;
    level_word[5:0]   = 6'(CW'(DEPTH) - cnt[0]);
    level_word[21:16] = 6'(cnt[1]);
  end
endmodule

module fifo_stat_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_push,
  input logic        host_pop,
  input logic        eng_take,
  input logic        eng_give,
  input logic        csr_wr,
  input logic [31:0] csr_wdata,
  input logic [31:0] host_rdata,
  input logic [31:0] stat_word,
  input logic [31:0] level_word
);
  AST_TX_OVF_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    host_push && stat_word[20] |=> stat_word[19]); // R5
  AST_RX_UNF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    host_pop && stat_word[23] |-> host_rdata == '0); // R6
  AST_RX_OVF_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    eng_give && stat_word[22] && !host_pop && !(csr_wr && csr_wdata[27])
    |=> $stable(level_word[21:16])); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[24] && !(csr_wr && csr_wdata[24]) |=> stat_word[24]); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    eng_take && stat_word[21] |=> stat_word[24]); // R10
  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr && csr_wdata[26]
    |=> level_word[5:0] == 6'(DEPTH) && stat_word[21] && !stat_word[26]); // R11
  AST_NOT_FULL_AND_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_word[20] && stat_word[21])); // R13
endmodule

bind fifo_stat_regs fifo_stat_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_push(host_push), .host_pop(host_pop),
  .eng_take(eng_take), .eng_give(eng_give), .csr_wr(csr_wr),
  .csr_wdata(csr_wdata), .host_rdata(host_rdata), .stat_word(stat_word),
  .level_word(level_word)
);

// File: tb/test_fifo_stat_regs.sv
module test_fifo_stat_regs;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [5:0]  ctl;   // {push, pop, take, give, wr, done}
    logic [31:0] din;
    logic [31:0] wdat;
    logic [31:0] exp_out;
    logic [31:0] exp_stat;
    logic [31:0] exp_lvl;
  } vec_t;

  localparam vec_t TBL [16] = '{
    '{6'h20, 32'hA1, 32'h0,        32'h0,  32'h00800000, 32'h0000001F}, // R3 push
    '{6'h20, 32'hB2, 32'h0,        32'h0,  32'h00800000, 32'h0000001E}, // R3 push
    '{6'h08, 32'h0,  32'h0,        32'hA1, 32'h00800000, 32'h0000001F}, // R3 take
    '{6'h08, 32'h0,  32'h0,        32'hB2, 32'h00A00000, 32'h00000020}, // R3 take
    '{6'h08, 32'h0,  32'h0,        32'h0,  32'h01A00000, 32'h00000020}, // R7 underflow
    '{6'h04, 32'hC3, 32'h0,        32'h0,  32'h01200000, 32'h00010020}, // R4 give
    '{6'h04, 32'hD4, 32'h0,        32'h0,  32'h01200000, 32'h00020020}, // R4 give
    '{6'h10, 32'h0,  32'h0,        32'hC3, 32'h01200000, 32'h00010020}, // R4 pop
    '{6'h10, 32'h0,  32'h0,        32'hD4, 32'h01A00000, 32'h00000020}, // R4 pop
    '{6'h10, 32'h0,  32'h0,        32'h0,  32'h01A40000, 32'h00000020}, // R6 underflow
    '{6'h02, 32'h0,  32'h01000000, 32'h0,  32'h00A40000, 32'h00000020}, // R9 clear
    '{6'h02, 32'h0,  32'h0,        32'h0,  32'h00A40000, 32'h00000020}, // R9 zero write
    '{6'h01, 32'h0,  32'h0,        32'h0,  32'h40A40000, 32'h00000020}, // R12 ready
    '{6'h02, 32'h0,  32'h40040000, 32'h0,  32'h00A00000, 32'h00000020}, // R9 clear two
    '{6'h28, 32'hE5, 32'h0,        32'h0,  32'h01800000, 32'h0000001F}, // R7 push+take empty
    '{6'h0A, 32'h0,  32'h01000000, 32'hE5, 32'h00A00000, 32'h00000020}  // R9 take+clear
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_push = 0, host_pop = 0, eng_take = 0, eng_give = 0;
  logic eng_busy = 0, eng_done = 0, csr_wr = 0;
  logic [31:0] host_wdata = '0, eng_rx_word = '0, csr_wdata = '0;
  logic [31:0] host_rdata, eng_tx_word, stat_word, level_word;
  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  fifo_stat_regs i_fifo_stat_regs (
    .clk(clk), .rst_n(rst_n),
    .host_push(host_push), .host_wdata(host_wdata),
    .host_pop(host_pop), .host_rdata(host_rdata),
    .eng_take(eng_take), .eng_tx_word(eng_tx_word),
    .eng_give(eng_give), .eng_rx_word(eng_rx_word),
    .eng_busy(eng_busy), .eng_done(eng_done),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .stat_word(stat_word), .level_word(level_word)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO check FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] c, input logic [31:0] d, w,
                       output logic [31:0] out);
    @(negedge clk);
    {host_push, host_pop, eng_take, eng_give, csr_wr, eng_done} = c;
    host_wdata = d; eng_rx_word = d; csr_wdata = w;
    #1 out = c[4] ? host_rdata : eng_tx_word;
    @(posedge clk);
    #1;
    {host_push, host_pop, eng_take, eng_give, csr_wr, eng_done} = '0;
    csr_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_bad++;
      $display("watchdog FAIL: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] o;
    #(CLK_PERIOD * 2 + 2);
    check("R1 stat in reset", stat_word, 32'h00A00000);
    rst_n = 1'b1;
    #(CLK_PERIOD);
    check("R1 stat", stat_word, 32'h00A00000);
    check("R1 level", level_word, 32'h00000020);

    for (int i = 0; i < 16; i++) begin
      drive(TBL[i].ctl, TBL[i].din, TBL[i].wdat, o);
      if (TBL[i].ctl[4] || TBL[i].ctl[3])
        check($sformatf("R3/R4 vec %0d data", i), o, TBL[i].exp_out);
      check($sformatf("R2 vec %0d stat", i), stat_word, TBL[i].exp_stat);
      check($sformatf("R3/R4 vec %0d level", i), level_word, TBL[i].exp_lvl);
    end

    // R13: fill transmit queue
    for (int i = 0; i < 32; i++) drive(6'h20, 32'd100 + i, 32'h0, o);
    check("R13 full stat", stat_word, 32'h00900000);
    check("R13 zero free", level_word, 32'h00000000);
    // R5: overflow push dropped
    drive(6'h20, 32'hDEAD, 32'h0, o);
    check("R5 ovf stat", stat_word, 32'h00980000);
    check("R5 level", level_word, 32'h00000000);
    for (int i = 0; i < 32; i++) begin
      drive(6'h08, 32'h0, 32'h0, o);
      check("R5 order kept", o, 32'd100 + i);
    end
    check("R5 drained", stat_word, 32'h00A80000);
    // R11: transmit flush with simultaneous push
    for (int i = 0; i < 3; i++) drive(6'h20, 32'h55 + i, 32'h0, o);
    drive(6'h22, 32'h77, 32'h04000000, o);
    check("R11 tx flush level", level_word, 32'h00000020);
    check("R11 tx flush stat", stat_word, 32'h00A80000);
    drive(6'h02, 32'h0, 32'h00080000, o);
    check("R9 clear ovf", stat_word, 32'h00A00000);
    // R10: set and clear together
    drive(6'h12, 32'h0, 32'h00040000, o);
    check("R10 set wins", stat_word, 32'h00A40000);
    drive(6'h02, 32'h0, 32'h00040000, o);
    check("R10 later clear", stat_word, 32'h00A00000);
    // R8: fill receive queue, then overflow
    for (int i = 0; i < 32; i++) drive(6'h04, 32'd200 + i, 32'h0, o);
    check("R8 rx full stat", stat_word, 32'h00600000);
    check("R8 rx full level", level_word, 32'h00200020);
    drive(6'h04, 32'hBEEF, 32'h0, o);
    check("R8 rx ovf stat", stat_word, 32'h02600000);
    check("R8 rx ovf level", level_word, 32'h00200020);
    drive(6'h10, 32'h0, 32'h0, o);
    check("R4 rx head", o, 32'd200);
    // R11: receive flush
    drive(6'h02, 32'h0, 32'h08000000, o);
    check("R11 rx flush level", level_word, 32'h00000020);
    check("R11 rx flush stat", stat_word, 32'h02A00000);
    // R12: busy is live
    @(negedge clk);
    eng_busy = 1'b1;
    #1 check("R12 busy", stat_word, 32'h82A00000);
    eng_busy = 1'b0;
    drive(6'h02, 32'h0, 32'h02000000, o);
    check("R9 clear rx ovf", stat_word, 32'h00A00000);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule